// File: doc/BRIEF.md
# Byte-Addressed Memory with Run-Time Endian Selection

This block is a small synchronous store in which every address names one byte, and consecutive addresses name consecutive bytes. One load/store port moves a byte, a halfword or a word per access. A single mode input picks the byte ordering. In big-endian order, the most significant byte of a value goes to the lowest address. In little-endian order, the least significant byte goes there.

Reads are combinational from the address, size and mode inputs. Writes take effect on the rising clock edge. Because the mode can change between a store and a later load, reading back part of a stored word shows which ordering was used. Narrow loads come back right-justified and padded with zeros. An access near the top of the array wraps to address zero, and no alignment is enforced.

Top module: `endian_mem`

## Requirements
- R1: While reset is low, and after it is released, every byte reads as zero.
- R2: Each address holds one byte. A 1-byte store (size 2'b00) changes only the addressed byte, and a 1-byte load returns it in rdata[7:0].
- R3: With big_endian high, an n-byte store puts value byte n-1 (most significant) at the start address, and then bytes of falling significance at rising addresses. Storing 0xA1B2C3D4 at 0x20 leaves A1, B2, C3, D4 at 0x20..0x23.
- R4: With big_endian low, an n-byte store puts value byte 0 (least significant) at the start address, and then bytes of rising significance at rising addresses. Storing 0x11223344 at 0x10 leaves 44, 33, 22, 11 at 0x10..0x13.
- R5: A load builds its value from the addressed bytes in the ordering the current mode selects. A load with the same address, size and mode as a store returns the stored value, masked to the access width.
- R6: The size input selects 1 byte for 2'b00, 2 bytes for 2'b01 and 4 bytes for 2'b10. The code 2'b11 behaves exactly like 2'b10.
- R7: A 1-byte load returns zeros in rdata[31:8], and a 2-byte load returns zeros in rdata[31:16].
- R8: A store changes only the 1, 2 or 4 addressed bytes. With wr_en low, nothing in the memory changes, whatever wdata holds.
- R9: rdata follows the inputs combinationally. In the cycle a store is presented, rdata shows the old contents. From the cycle after the clock edge, rdata shows the new bytes.
- R10: Byte addresses of an access are taken modulo DEPTH, so an access may start at any address and may wrap from the last address to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all bytes |
| addr | input | AW (6) | Byte address of the lowest byte of the access |
| size | input | 2 | Access width code: 00 byte, 01 halfword, 10 or 11 word |
| wr_en | input | 1 | High to store on the next rising edge |
| big_endian | input | 1 | High for big-endian ordering, low for little-endian ordering |
| wdata | input | 32 | Value to store, right-justified |
| rdata | output | 32 | Loaded value, right-justified and zero-extended |

## Verification
The main test stores a word with one ordering. It then reads the word back with loads of every width, at each byte offset, and in both modes. Single-byte loads at 0x20..0x23 show the exact placement of each byte. Whole-word loads in the opposite mode show the full byte reversal. A halfword store followed by a word load shows that only two bytes are written. A byte store into the middle of an earlier word shows that the neighbouring bytes are left alone. Unaligned accesses and accesses that wrap at the top of the array show the modulo addressing. Size code 11 is compared against code 10. Held inputs with wr_en low show that wdata is ignored when no store is requested.

// File: rtl/emem_pkg.sv
package emem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  // number of bytes moved by an access of the given size code
  function automatic int unsigned span_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: span_bytes = 1;
      SZ_HALF: span_bytes = 2;
      default: span_bytes = 4;
    endcase
  endfunction

  // which byte of the right-justified value travels on address lane k
  function automatic int unsigned value_byte(input int unsigned k,
                                             input int unsigned n,
                                             input logic        big);
    if (k >= n)   value_byte = 0;
    else if (big) value_byte = n - 1 - k;
    else          value_byte = k;
  endfunction

  // byte address of lane k, modulo the memory depth
  function automatic int unsigned lane_byte_addr(input int unsigned base,
                                                 input int unsigned k,
                                                 input int unsigned depth);
    lane_byte_addr = (base + k) % depth;
  endfunction

endpackage

// File: rtl/emem_lane_map.sv
module emem_lane_map
  import emem_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NLANE = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int LSW   = $clog2(NLANE)
) (
  input  logic [AW-1:0]             addr,
  input  logic [1:0]                size,
  input  logic                      wr_en,
  input  logic                      big_endian,
  output logic [NLANE-1:0][AW-1:0]  lane_addr,
  output logic [NLANE-1:0][LSW-1:0] lane_sel,
  output logic [NLANE-1:0]          lane_act,
  output logic [NLANE-1:0]          lane_we
);

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    always_comb begin
      lane_act[k]  = (k < span_bytes(size));
      lane_we[k]   = lane_act[k] && wr_en;
      lane_sel[k]  = LSW'(value_byte(k, span_bytes(size), big_endian));
      lane_addr[k] = AW'(lane_byte_addr(int'(addr), k, DEPTH));
    end
  end

endmodule

// File: rtl/emem_byte_store.sv
module emem_byte_store #(
  parameter int DEPTH = 64,
  parameter int NLANE = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLANE-1:0]         lane_we,
  input  logic [NLANE-1:0][AW-1:0] lane_addr,
  input  logic [NLANE-1:0][7:0]    lane_wbyte,
  output logic [NLANE-1:0][7:0]    lane_rbyte
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      for (int k = 0; k < NLANE; k++) begin
        if (lane_we[k]) mem[lane_addr[k]] <= lane_wbyte[k];
      end
    end
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_rd
    assign lane_rbyte[k] = mem[lane_addr[k]];
  end

endmodule

// File: rtl/emem_load_pack.sv
module emem_load_pack #(
  parameter int NLANE = 4,
  parameter int LSW   = $clog2(NLANE),
  parameter int DW    = 8 * NLANE
) (
  input  logic [NLANE-1:0]          lane_act,
  input  logic [NLANE-1:0][LSW-1:0] lane_sel,
  input  logic [NLANE-1:0][7:0]     lane_rbyte,
  output logic [DW-1:0]             rdata
);

  // inactive lanes contribute nothing, which gives the zero extension
  always_comb begin
    rdata = '0;
    for (int j = 0; j < NLANE; j++) begin
      for (int k = 0; k < NLANE; k++) begin
        if (lane_act[k] && (lane_sel[k] == LSW'(j))) rdata[8*j +: 8] = lane_rbyte[k];
      end
    end
  end

endmodule

// File: rtl/endian_mem.sv
module endian_mem #(
  parameter int DEPTH = 64,
  parameter int NLANE = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8 * NLANE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          wr_en,
  input  logic          big_endian,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int LSW = $clog2(NLANE);

  // per-lane events, brought out for the checker and for waveform reading
  logic [NLANE-1:0][AW-1:0]  lane_addr;
  logic [NLANE-1:0][LSW-1:0] lane_sel;
  logic [NLANE-1:0]          lane_act;
  logic [NLANE-1:0]          lane_we;
  logic [NLANE-1:0][7:0]     lane_wbyte;
  logic [NLANE-1:0][7:0]     lane_rbyte;

  emem_lane_map #(.DEPTH(DEPTH), .NLANE(NLANE), .AW(AW), .LSW(LSW)) u_map (
    .addr       (addr),
    .size       (size),
    .wr_en      (wr_en),
    .big_endian (big_endian),
    .lane_addr  (lane_addr),
    .lane_sel   (lane_sel),
    .lane_act   (lane_act),
    .lane_we    (lane_we)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_wb
    assign lane_wbyte[k] = wdata[8*lane_sel[k] +: 8];
  end

  emem_byte_store #(.DEPTH(DEPTH), .NLANE(NLANE), .AW(AW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_we    (lane_we),
    .lane_addr  (lane_addr),
    .lane_wbyte (lane_wbyte),
    .lane_rbyte (lane_rbyte)
  );

  emem_load_pack #(.NLANE(NLANE), .LSW(LSW), .DW(DW)) u_pack (
    .lane_act   (lane_act),
    .lane_sel   (lane_sel),
    .lane_rbyte (lane_rbyte),
    .rdata      (rdata)
  );

endmodule

// File: rtl/endian_mem_chk.sv
module endian_mem_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [1:0]    size,
  input logic          wr_en,
  input logic          big_endian,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata
);

  logic [DW-1:0] keep_mask;
  always_comb begin
    case (size)
      2'b00:   keep_mask = DW'(32'h0000_00FF);
      2'b01:   keep_mask = DW'(32'h0000_FFFF);
      default: keep_mask = '1;
    endcase
  end

  // R5: a load matching the previous store's address, size and mode returns it
  p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $stable(addr) && $stable(size) && $stable(big_endian))
      |-> (rdata == ($past(wdata) & keep_mask)));

  // R7: narrow loads are zero-extended
  p_byte_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b00) |-> (rdata[DW-1:8] == '0));

  p_half_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b01) |-> (rdata[DW-1:16] == '0));

  // R8: with no store requested and the address held, the read value holds
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(addr) && $stable(size) && $stable(big_endian))
      |-> $stable(rdata));

endmodule

bind endian_mem endian_mem_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .size       (size),
  .wr_en      (wr_en),
  .big_endian (big_endian),
  .wdata      (wdata),
  .rdata      (rdata)
);

// File: tb/endian_mem_tb.sv
`timescale 1ns/1ps
module endian_mem_tb;

  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  typedef struct packed {
    logic        wr;
    logic        be;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 2'b10, 8'h20, 32'hA1B2C3D4, 32'h0, 4'd3},  // R3 store BE word
    '{1'b0, 1'b1, 2'b00, 8'h20, 32'h0, 32'h000000A1, 4'd3},  // R3
    '{1'b0, 1'b1, 2'b00, 8'h21, 32'h0, 32'h000000B2, 4'd3},  // R3
    '{1'b0, 1'b0, 2'b00, 8'h22, 32'h0, 32'h000000C3, 4'd3},  // R3 mode-free byte
    '{1'b0, 1'b1, 2'b00, 8'h23, 32'h0, 32'h000000D4, 4'd3},  // R3
    '{1'b0, 1'b1, 2'b01, 8'h22, 32'h0, 32'h0000C3D4, 4'd7},  // R7 half BE
    '{1'b0, 1'b1, 2'b10, 8'h20, 32'h0, 32'hA1B2C3D4, 4'd5},  // R5
    '{1'b0, 1'b0, 2'b10, 8'h20, 32'h0, 32'hD4C3B2A1, 4'd5},  // R5 LE view
    '{1'b0, 1'b0, 2'b01, 8'h20, 32'h0, 32'h0000B2A1, 4'd5},  // R5 half LE
    '{1'b1, 1'b0, 2'b10, 8'h10, 32'h11223344, 32'h0, 4'd4},  // R4 store LE
    '{1'b0, 1'b0, 2'b00, 8'h11, 32'h0, 32'h00000033, 4'd4},  // R4
    '{1'b0, 1'b1, 2'b00, 8'h10, 32'h0, 32'h00000044, 4'd4},  // R4
    '{1'b0, 1'b1, 2'b10, 8'h10, 32'h0, 32'h44332211, 4'd5},  // R5 BE view
    '{1'b1, 1'b1, 2'b01, 8'h30, 32'hFFFF5566, 32'h0, 4'd8},  // R8 half store
    '{1'b0, 1'b1, 2'b10, 8'h30, 32'h0, 32'h55660000, 4'd8},  // R8
    '{1'b0, 1'b0, 2'b01, 8'h30, 32'h0, 32'h00006655, 4'd7},  // R7
    '{1'b1, 1'b0, 2'b00, 8'h12, 32'hAABBCC99, 32'h0, 4'd2},  // R2 byte store
    '{1'b0, 1'b0, 2'b10, 8'h10, 32'h0, 32'h11993344, 4'd2},  // R2
    '{1'b1, 1'b1, 2'b11, 8'h08, 32'h01020304, 32'h0, 4'd6},  // R6 code 11 store
    '{1'b0, 1'b0, 2'b10, 8'h08, 32'h0, 32'h04030201, 4'd6},  // R6
    '{1'b0, 1'b1, 2'b11, 8'h09, 32'h0, 32'h02030400, 4'd10}, // R10 unaligned
    '{1'b1, 1'b1, 2'b10, 8'h3E, 32'hCAFEBABE, 32'h0, 4'd10}, // R10 wrap store
    '{1'b0, 1'b0, 2'b01, 8'h3F, 32'h0, 32'h0000BAFE, 4'd10}, // R10
    '{1'b0, 1'b1, 2'b10, 8'h3E, 32'h0, 32'hCAFEBABE, 4'd10}  // R10
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = 2'b00;
  logic          wr_en = 1'b0;
  logic          big_endian = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  endian_mem #(.DEPTH(DEPTH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .size       (size),
    .wr_en      (wr_en),
    .big_endian (big_endian),
    .wdata      (wdata),
    .rdata      (rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic be, input logic [1:0] sz,
                       input logic [7:0] a, input logic [31:0] d);
    wr_en = w; big_endian = be; size = sz; addr = a[AW-1:0]; wdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: contents read zero in reset
    drive(1'b0, 1'b1, 2'b10, 8'h20, 32'h0);
    #1 check("R1 in reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b0, 2'b10, 8'h3E, 32'h0);
    #1 check("R1 after reset", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].wr, VECS[i].be, VECS[i].sz, VECS[i].addr, VECS[i].wd);
      #1;
      if (!VECS[i].wr) check($sformatf("R%0d vector %0d", VECS[i].req, i), rdata, VECS[i].exp);
    end

    // R8: wr_en low with new data leaves contents alone
    @(negedge clk);
    drive(1'b0, 1'b1, 2'b10, 8'h20, 32'hFFFFFFFF);
    @(negedge clk);
    #1 check("R8 no write when wr_en low", rdata, 32'hA1B2C3D4);

    // R9: old contents before the edge, new contents after it
    @(negedge clk);
    drive(1'b1, 1'b1, 2'b10, 8'h28, 32'h12345678);
    #1 check("R9 before edge", rdata, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9 after edge", rdata, 32'h12345678);

    // R1: reset clears stored bytes again
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 clear on reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 2'b10, 8'h20, 32'h0);
    #1 check("R1 word at 0x20 cleared", rdata, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule